// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point words laid out in the standard single-precision format: a sign bit, an 8-bit biased exponent and a 23-bit fraction. A one-cycle `start` pulse captures both operands and the operation select. The result appears with a one-cycle `done` pulse a fixed number of cycles later. The unit is iterative and not pipelined, so a new operation may only start once `done` has been seen. Rounding is always to nearest, with ties going to the even value.

Corner cases are deliberately simplified. Denormal operands are not computed: they give a quiet NaN and raise a flag. Results too small to be normal are flushed to a signed zero. Any NaN operand gives a single canonical NaN instead of passing a payload through. Four sticky status flags (overflow, underflow, invalid, denormal operand) accumulate across operations until software pulses `clrFlags`.

Top module: `fp_addsub_unit`

## Requirements
- R1: While `rstN` is low and after its release, `result` is 0, `done` is 0 and all four flags are 0.
- R2: For finite normal operands, `result` is the correctly rounded (nearest, ties to even) value of A+B when `opSub`=0 and of A-B when `opSub`=1; subtraction inverts B's sign bit 31.
- R3: An exact sum lying halfway between two representable values rounds to the one whose fraction LSB (bit 0) is 0.
- R4: If either operand is a NaN (exponent bits 30:23 all ones, fraction nonzero), `result` is 0xFFC00000 whatever the payloads, and no flag is raised by that operation.
- R5: If either operand is denormal (exponent 0, fraction nonzero), `result` is 0xFFC00000 and `flagDen` is set; this takes priority over NaN and infinity handling.
- R6: A rounded result with biased exponent below 1 is returned as zero carrying the computed sign (0x00000000 or 0x80000000) and `flagUnf` is set.
- R7: A rounded result with biased exponent of 255 or more, including overflow caused by rounding, is returned as infinity with the computed sign (exponent all ones, fraction 0) and `flagOvf` is set.
- R8: Infinities of opposite effective sign give 0xFFC00000 and set `flagInv`. An infinity combined with a finite value, or with an infinity of the same effective sign, returns that infinity.
- R9: When finite nonzero operands cancel exactly, the result is +0 (0x00000000) and no flag is raised.
- R10: Each flag stays set until `clrFlags` is sampled high, which zeroes it on that edge. A flag raised by an operation finishing on that same edge is kept.
- R11: `done` is high for exactly one cycle, on the fifth rising edge after the edge that sampled `start` high. A `start` pulse while an operation is in flight is ignored.
- R12: The sum of two zeros is -0 only when both effective signs are negative, and +0 otherwise. Zero combined with a finite nonzero value returns that value unchanged (with B's sign inverted for subtraction).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation on the current operands |
| opSub | input | 1 | 1 selects A-B, 0 selects A+B |
| opA | input | 32 | Operand A, single-precision |
| opB | input | 32 | Operand B, single-precision |
| clrFlags | input | 1 | Clears all sticky flags |
| result | output | 32 | Result of the last completed operation |
| done | output | 1 | One-cycle completion pulse |
| flagOvf | output | 1 | Sticky overflow flag |
| flagUnf | output | 1 | Sticky underflow flag |
| flagInv | output | 1 | Sticky invalid-operation flag |
| flagDen | output | 1 | Sticky denormal-operand flag |

## Verification
Internal datapath state is visible only once per operation, at the `done` pulse five cycles after `start`. A corrupted alignment shift or a lost sticky bit shows up there as a result one unit in the last place off, most often on ties and on near-cancelling subtractions. A wrong normalisation count shows as a grossly wrong exponent in the same cycle. Flag state errors can hide much longer: a flag that falls without a clear or rises without cause is only exposed when the flags are next compared after an operation or a clear. The bench therefore compares the flags after every operation, not only after the operations meant to raise them.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MANT_W = FRAC_W + 1;
  localparam int GRS_W  = 3;
  localparam int ALN_W  = MANT_W + GRS_W;
  localparam int SUM_W  = ALN_W + 1;
  localparam int EXPI_W = EXP_W + 2;
  localparam int LZ_W   = $clog2(ALN_W + 1);
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam logic [WORD_W-1:0] QNAN_WORD = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inv;
    logic den;
  } fpasFlags_t;

  typedef struct packed {
    logic load;
    logic align;
    logic add;
    logic norm;
    logic round;
  } fpasStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ALIGN, ST_ADD, ST_NORM, ST_ROUND
  } fpasState_t;

  // Number of leading zeros; the highest set bit wins because it is scanned last.
  function automatic logic [LZ_W-1:0] countLead(input logic [ALN_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = LZ_W'(ALN_W);
    for (int i = 0; i < ALN_W; i++) begin
      if (v[i]) n = LZ_W'(ALN_W - 1 - i);
    end
    return n;
  endfunction
endpackage

// File: rtl/fpas_ctrl.sv
module fpas_ctrl
  import fpas_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output fpasStrobe_t strobe,
  output logic        done
);
  fpasState_t state;

  always_comb begin
    strobe       = '0;
    strobe.load  = (state == ST_IDLE) && start;
    strobe.align = (state == ST_ALIGN);
    strobe.add   = (state == ST_ADD);
    strobe.norm  = (state == ST_NORM);
    strobe.round = (state == ST_ROUND);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_ROUND);
      unique case (state)
        ST_IDLE:  if (start) state <= ST_ALIGN;
        ST_ALIGN: state <= ST_ADD;
        ST_ADD:   state <= ST_NORM;
        ST_NORM:  state <= ST_ROUND;
        ST_ROUND: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpas_datapath.sv
module fpas_datapath
  import fpas_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fpasStrobe_t       strobe,
  input  logic              opSub,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              clrFlags,
  output logic [WORD_W-1:0] result,
  output fpasFlags_t        flags
);
  localparam logic signed [EXPI_W-1:0] EXP_TOP = EXPI_W'(EXP_MAX);
  localparam logic signed [EXPI_W-1:0] EXP_ONE = EXPI_W'(1);

  // ---------------- operand classification (load stage) ----------------
  logic              aSign, bSign;
  logic [EXP_W-1:0]  aExp, bExp;
  logic [FRAC_W-1:0] aFrac, bFrac;
  logic aNan, bNan, aInf, bInf, aZero, bZero, aDen, bDen, aBigger;

  always_comb begin
    aSign = opA[WORD_W-1];
    bSign = opB[WORD_W-1] ^ opSub;
    aExp  = opA[WORD_W-2 -: EXP_W];
    bExp  = opB[WORD_W-2 -: EXP_W];
    aFrac = opA[FRAC_W-1:0];
    bFrac = opB[FRAC_W-1:0];
    aNan  = (aExp == EXP_W'(EXP_MAX)) && (aFrac != '0);
    bNan  = (bExp == EXP_W'(EXP_MAX)) && (bFrac != '0);
    aInf  = (aExp == EXP_W'(EXP_MAX)) && (aFrac == '0);
    bInf  = (bExp == EXP_W'(EXP_MAX)) && (bFrac == '0);
    aZero = (aExp == '0) && (aFrac == '0);
    bZero = (bExp == '0) && (bFrac == '0);
    aDen  = (aExp == '0) && (aFrac != '0);
    bDen  = (bExp == '0) && (bFrac != '0);
    aBigger = {aExp, aFrac} >= {bExp, bFrac};
  end

  logic              specHit;
  logic [WORD_W-1:0] specVal;
  fpasFlags_t        specFlg;

  always_comb begin
    specHit = 1'b1;
    specVal = QNAN_WORD;
    specFlg = '0;
    if (aDen || bDen)            specFlg.den = 1'b1;
    else if (aNan || bNan)       specVal = QNAN_WORD;
    else if (aInf && bInf) begin
      if (aSign != bSign)        specFlg.inv = 1'b1;
      else                       specVal = opA;
    end
    else if (aInf)               specVal = opA;
    else if (bInf)               specVal = {bSign, opB[WORD_W-2:0]};
    else if (aZero && bZero)     specVal = {aSign & bSign, {(WORD_W-1){1'b0}}};
    else if (aZero)              specVal = {bSign, opB[WORD_W-2:0]};
    else if (bZero)              specVal = opA;
    else                         specHit = 1'b0;
  end

  // Operation context, held from load until the next load.
  logic                     s1Special, s1Sign, s1Sub;
  logic [WORD_W-1:0]        s1SpecVal;
  fpasFlags_t               s1SpecFlg;
  logic signed [EXPI_W-1:0] s1Exp;
  logic [MANT_W-1:0]        s1MBig, s1MSmall;
  logic [EXP_W-1:0]         s1Shift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Special <= 1'b0;
      s1Sign    <= 1'b0;
      s1Sub     <= 1'b0;
      s1SpecVal <= '0;
      s1SpecFlg <= '0;
      s1Exp     <= '0;
      s1MBig    <= '0;
      s1MSmall  <= '0;
      s1Shift   <= '0;
    end else if (strobe.load) begin
      s1Special <= specHit;
      s1SpecVal <= specVal;
      s1SpecFlg <= specFlg;
      s1Sub     <= aSign ^ bSign;
      s1Sign    <= aBigger ? aSign : bSign;
      s1Exp     <= $signed({{(EXPI_W-EXP_W){1'b0}}, (aBigger ? aExp : bExp)});
      s1MBig    <= aBigger ? {1'b1, aFrac} : {1'b1, bFrac};
      s1MSmall  <= aBigger ? {1'b1, bFrac} : {1'b1, aFrac};
      s1Shift   <= aBigger ? (aExp - bExp) : (bExp - aExp);
    end
  end

  // ---------------- alignment with guard/round/sticky ----------------
  logic [ALN_W-1:0] alnExt, alnShifted, alnNext, s2Aligned;
  logic             alnLost;

  always_comb begin
    alnExt = {s1MSmall, {GRS_W{1'b0}}};
    if (int'(s1Shift) >= ALN_W) begin
      alnShifted = '0;
      alnLost    = 1'b1;
    end else begin
      alnShifted = alnExt >> s1Shift;
      alnLost    = |(alnExt & ~({ALN_W{1'b1}} << s1Shift));
    end
    alnNext = {alnShifted[ALN_W-1:1], alnShifted[0] | alnLost};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             s2Aligned <= '0;
    else if (strobe.align) s2Aligned <= alnNext;
  end

  // ---------------- magnitude add or subtract ----------------
  logic [SUM_W-1:0] bigExt, smallExt, s3Sum;

  always_comb begin
    bigExt   = {1'b0, s1MBig, {GRS_W{1'b0}}};
    smallExt = {1'b0, s2Aligned};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           s3Sum <= '0;
    else if (strobe.add) s3Sum <= s1Sub ? (bigExt - smallExt) : (bigExt + smallExt);
  end

  // ---------------- normalisation ----------------
  logic [LZ_W-1:0]          lzCnt;
  logic [ALN_W-1:0]         normM, s4M;
  logic signed [EXPI_W-1:0] normExp, s4Exp;
  logic                     s4Zero;

  always_comb begin
    lzCnt = countLead(s3Sum[ALN_W-1:0]);
    if (s3Sum[SUM_W-1]) begin
      normM   = {s3Sum[SUM_W-1:2], s3Sum[1] | s3Sum[0]};
      normExp = s1Exp + EXP_ONE;
    end else begin
      normM   = s3Sum[ALN_W-1:0] << lzCnt;
      normExp = s1Exp - $signed({{(EXPI_W-LZ_W){1'b0}}, lzCnt});
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s4M    <= '0;
      s4Exp  <= '0;
      s4Zero <= 1'b0;
    end else if (strobe.norm) begin
      s4M    <= normM;
      s4Exp  <= normExp;
      s4Zero <= (s3Sum == '0);
    end
  end

  // ---------------- rounding, range check, packing ----------------
  logic                     rndUp;
  logic [MANT_W:0]          rndMant;
  logic signed [EXPI_W-1:0] rndExp;
  logic [WORD_W-1:0]        outVal;
  fpasFlags_t               outFlg;

  always_comb begin
    rndUp   = s4M[GRS_W-1] & ((|s4M[GRS_W-2:0]) | s4M[GRS_W]);
    rndMant = {1'b0, s4M[ALN_W-1:GRS_W]} + {{MANT_W{1'b0}}, rndUp};
    rndExp  = s4Exp + $signed({{(EXPI_W-1){1'b0}}, rndMant[MANT_W]});
    outFlg  = '0;
    if (s1Special) begin
      outVal = s1SpecVal;
      outFlg = s1SpecFlg;
    end else if (s4Zero) begin
      outVal = '0;
    end else if (rndExp >= EXP_TOP) begin
      outVal     = {s1Sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      outFlg.ovf = 1'b1;
    end else if (rndExp < EXP_ONE) begin
      outVal     = {s1Sign, {(WORD_W-1){1'b0}}};
      outFlg.unf = 1'b1;
    end else begin
      outVal = {s1Sign, rndExp[EXP_W-1:0], rndMant[FRAC_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      flags  <= '0;
    end else begin
      if (strobe.round) result <= outVal;
      flags <= fpasFlags_t'((clrFlags ? '0 : flags) | (strobe.round ? outFlg : '0));
    end
  end
endmodule

// File: rtl/fp_addsub_unit.sv
module fp_addsub_unit
  import fpas_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opSub,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              clrFlags,
  output logic [WORD_W-1:0] result,
  output logic              done,
  output logic              flagOvf,
  output logic              flagUnf,
  output logic              flagInv,
  output logic              flagDen
);
  fpasStrobe_t strobe;
  fpasFlags_t  flags;

  fpas_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  fpas_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opSub    (opSub),
    .opA      (opA),
    .opB      (opB),
    .clrFlags (clrFlags),
    .result   (result),
    .flags    (flags)
  );

  assign flagOvf = flags.ovf;
  assign flagUnf = flags.unf;
  assign flagInv = flags.inv;
  assign flagDen = flags.den;
endmodule

// File: rtl/fpas_checker.sv
module fpas_checker
  import fpas_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              clrFlags,
  input logic [WORD_W-1:0] result,
  input logic              done,
  input logic              flagOvf,
  input logic              flagUnf,
  input logic              flagInv,
  input logic              flagDen
);
  logic [EXP_W-1:0]  resExp;
  logic [FRAC_W-1:0] resFrac;
  assign resExp  = result[WORD_W-2 -: EXP_W];
  assign resFrac = result[FRAC_W-1:0];

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start, 5));

  a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!clrFlags && (flagOvf || flagUnf || flagInv || flagDen)) |=>
      ($countones({flagOvf, flagUnf, flagInv, flagDen}) >=
       $countones($past({flagOvf, flagUnf, flagInv, flagDen}))));

  a_r10_ovf_keep: assert property (@(posedge clk) disable iff (!rstN)
    (flagOvf && !clrFlags) |=> flagOvf);

  a_r10_rise_with_done: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flagOvf) || $rose(flagUnf) || $rose(flagInv) || $rose(flagDen)) |-> done);

  a_r6_no_denormal_out: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !((resExp == '0) && (resFrac != '0)));

  a_r4_nan_canonical: assert property (@(posedge clk) disable iff (!rstN)
    (done && (resExp == EXP_W'(EXP_MAX)) && (resFrac != '0)) |-> (result == QNAN_WORD));

  a_r7_ovf_is_inf: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagOvf) |-> ((resExp == EXP_W'(EXP_MAX)) && (resFrac == '0)));
endmodule

bind fp_addsub_unit fpas_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .clrFlags (clrFlags),
  .result   (result),
  .done     (done),
  .flagOvf  (flagOvf),
  .flagUnf  (flagUnf),
  .flagInv  (flagInv),
  .flagDen  (flagDen)
);

// File: tb/fp_addsub_unit_tb_top.sv
`timescale 1ns/1ps
module fp_addsub_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        opSub = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        clrFlags = 1'b0;
  logic [31:0] result;
  logic        done, flagOvf, flagUnf, flagInv, flagDen;

  int checks = 0;
  int errors = 0;
  logic [3:0] expFlags = '0;

  always #10 clk = ~clk;

  fp_addsub_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opSub(opSub), .opA(opA), .opB(opB),
    .clrFlags(clrFlags), .result(result), .done(done),
    .flagOvf(flagOvf), .flagUnf(flagUnf), .flagInv(flagInv), .flagDen(flagDen)
  );

  // Expected {ovf,unf,inv,den, result} from the requirements, with wide exact arithmetic.
  function automatic logic [35:0] refOp(input logic [31:0] a, input logic [31:0] b, input logic sub);
    logic sa, sb, sBig, sSmall;
    int ea, eb, eBig, eSmall, d, p, e;
    logic [22:0] fa, fb;
    logic [63:0] mBig, mSmall, sh;
    logic st, half, rest, up;
    logic [65:0] x, y, s, nrm;
    logic [23:0] mant;
    logic [24:0] mr;
    sa = a[31]; sb = b[31] ^ sub;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    fa = a[22:0]; fb = b[22:0];
    if ((ea == 0 && fa != 0) || (eb == 0 && fb != 0)) return {4'b0001, 32'hFFC00000};
    if ((ea == 255 && fa != 0) || (eb == 255 && fb != 0)) return {4'b0000, 32'hFFC00000};
    if (ea == 255 && eb == 255) return (sa != sb) ? {4'b0010, 32'hFFC00000} : {4'b0000, a};
    if (ea == 255) return {4'b0000, a};
    if (eb == 255) return {4'b0000, sb, b[30:0]};
    if (ea == 0 && eb == 0) return {4'b0000, sa & sb, 31'b0};
    if (ea == 0) return {4'b0000, sb, b[30:0]};
    if (eb == 0) return {4'b0000, a};
    if (ea < eb || (ea == eb && fa < fb)) begin
      sBig = sb; eBig = eb; mBig = {1'b1, fb, 40'b0};
      sSmall = sa; eSmall = ea; mSmall = {1'b1, fa, 40'b0};
    end else begin
      sBig = sa; eBig = ea; mBig = {1'b1, fa, 40'b0};
      sSmall = sb; eSmall = eb; mSmall = {1'b1, fb, 40'b0};
    end
    d = eBig - eSmall;
    if (d >= 64) begin sh = '0; st = 1'b1; end
    else begin
      sh = mSmall >> d;
      st = |(mSmall & ~({64{1'b1}} << d));
    end
    x = {1'b0, mBig, 1'b0};
    y = {1'b0, sh, st};
    s = (sBig != sSmall) ? (x - y) : (x + y);
    if (s == '0) return {4'b0000, 32'h0};
    p = 0;
    for (int i = 0; i < 66; i++) if (s[i]) p = i;
    e = eBig + p - 64;
    nrm = s << (65 - p);
    mant = nrm[65:42];
    half = nrm[41];
    rest = |nrm[40:0];
    up = half & (rest | mant[0]);
    mr = {1'b0, mant} + {24'b0, up};
    if (mr[24]) begin e = e + 1; mant = 24'h800000; end
    else mant = mr[23:0];
    if (e >= 255) return {4'b1000, sBig, 8'hFF, 23'b0};
    if (e <= 0) return {4'b0100, sBig, 31'b0};
    return {4'b0000, sBig, e[7:0], mant[22:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, expv, $time);
    end
  endtask

  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic sub, input string tag);
    logic [35:0] ref36;
    int k;
    ref36 = refOp(a, b, sub);
    @(negedge clk);
    opA = a; opB = b; opSub = sub; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 20) begin @(negedge clk); k++; end
    chk(k == 5, "R11 latency", 32'(k), 32'd5);
    chk(result == ref36[31:0], tag, result, ref36[31:0]);
    expFlags = expFlags | ref36[35:32];
    chk({flagOvf, flagUnf, flagInv, flagDen} == expFlags, "R10 flags",
        {28'b0, flagOvf, flagUnf, flagInv, flagDen}, {28'b0, expFlags});
    @(negedge clk);
    chk(!done, "R11 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic clearFlags();
    @(negedge clk); clrFlags = 1'b1;
    @(negedge clk); clrFlags = 1'b0;
    expFlags = '0;
    chk({flagOvf, flagUnf, flagInv, flagDen} == 4'b0, "R10 clear",
        {28'b0, flagOvf, flagUnf, flagInv, flagDen}, 32'd0);
  endtask

  function automatic logic [31:0] randNorm(input int baseExp, input int spread);
    int e;
    e = baseExp + int'($urandom % (2 * spread + 1)) - spread;
    if (e < 1) e = 1;
    if (e > 254) e = 254;
    return {1'(($urandom) & 1), e[7:0], 23'($urandom)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int bcount;
    logic [31:0] firstRes;
    logic [35:0] ref36;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(result == 0 && !done && {flagOvf, flagUnf, flagInv, flagDen} == 0, "R1 in reset",
        result, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(result == 0 && !done && {flagOvf, flagUnf, flagInv, flagDen} == 0, "R1 after release",
        result, 32'h0);

    // R2: directed normal cases
    runOp(32'h3F800000, 32'h40000000, 1'b0, "R2 1+2");
    runOp(32'h40490FDB, 32'h3F800000, 1'b1, "R2 pi-1");
    runOp(32'hC1200000, 32'h3DCCCCCD, 1'b0, "R2 -10+0.1");
    runOp(32'h3F800001, 32'h3F800000, 1'b1, "R2 cancel to ulp");
    // R3: ties to even
    runOp(32'h3F800000, 32'h33800000, 1'b0, "R3 tie even stays");
    runOp(32'h3F800001, 32'h33800000, 1'b0, "R3 tie odd rounds up");
    runOp(32'h3F800000, 32'h34400000, 1'b0, "R3 above half");
    // R4: NaN inputs
    runOp(32'h7FC12345, 32'h3F800000, 1'b0, "R4 qnan A");
    runOp(32'h40000000, 32'hFF800001, 1'b1, "R4 snan B");
    // R5: denormal inputs
    runOp(32'h00000001, 32'h3F800000, 1'b0, "R5 den A");
    runOp(32'h7FC00000, 32'h807FFFFF, 1'b0, "R5 den over nan");
    clearFlags();
    // R6: underflow
    runOp(32'h00C00000, 32'h00800000, 1'b1, "R6 underflow +");
    runOp(32'h00800000, 32'h00C00000, 1'b1, "R6 underflow -");
    clearFlags();
    // R7: overflow
    runOp(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, "R7 overflow +");
    runOp(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, "R7 overflow -");
    runOp(32'h7F7FFFFF, 32'h73000000, 1'b0, "R7 overflow by rounding");
    // R10: flags survive unrelated operations until cleared
    runOp(32'h3F800000, 32'h3F800000, 1'b0, "R10 quiet op keeps flags");
    clearFlags();
    // R8: infinities
    runOp(32'h7F800000, 32'h7F800000, 1'b1, "R8 inf-inf");
    runOp(32'h7F800000, 32'hFF800000, 1'b0, "R8 inf+-inf");
    runOp(32'hFF800000, 32'h7F800000, 1'b1, "R8 -inf-inf");
    runOp(32'h3F800000, 32'h7F800000, 1'b1, "R8 1-inf");
    clearFlags();
    // R9: exact cancellation
    runOp(32'h40490FDB, 32'h40490FDB, 1'b1, "R9 x-x");
    runOp(32'hC0490FDB, 32'h40490FDB, 1'b0, "R9 -x+x");
    // R12: zeros
    runOp(32'h80000000, 32'h80000000, 1'b0, "R12 -0+-0");
    runOp(32'h00000000, 32'h80000000, 1'b0, "R12 +0+-0");
    runOp(32'h80000000, 32'h00000000, 1'b1, "R12 -0-+0");
    runOp(32'h00000000, 32'h3FC00000, 1'b1, "R12 0-1.5");

    // R11: start while busy is ignored
    ref36 = refOp(32'h40400000, 32'h3F800000, 1'b0);
    @(negedge clk); opA = 32'h40400000; opB = 32'h3F800000; opSub = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); opA = 32'h42000000; opB = 32'h41000000; opSub = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    bcount = 0; firstRes = '0;
    for (int i = 0; i < 12; i++) begin
      if (done) begin
        if (bcount == 0) firstRes = result;
        bcount++;
      end
      @(negedge clk);
    end
    chk(bcount == 1, "R11 busy start ignored count", 32'(bcount), 32'd1);
    chk(firstRes == ref36[31:0], "R11 busy start ignored value", firstRes, ref36[31:0]);

    // Random stimulus
    for (int n = 0; n < 600; n++) begin
      logic [31:0] ra, rb;
      int mode, be;
      mode = int'($urandom % 5);
      be = 1 + int'($urandom % 254);
      case (mode)
        0: begin ra = randNorm(be, 127); rb = randNorm(be, 127); end
        1: begin ra = randNorm(be, 1); rb = randNorm(be, 1); end
        2: begin ra = $urandom; rb = $urandom; end
        3: begin ra = randNorm(252, 2); rb = randNorm(252, 2); end
        default: begin ra = randNorm(3, 2); rb = randNorm(3, 2); end
      endcase
      if (mode == 1 && ($urandom % 4) == 0) rb = {~ra[31], ra[30:3], 3'($urandom)};
      runOp(ra, rb, 1'($urandom & 1), "R2 random");
      if ((n % 60) == 59) clearFlags();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule